// File: doc/BRIEF.md
# Dual-mode DMA channel engine

A single DMA channel that copies words under the control of a small register set. Software writes a source address, a destination address and a unit count. It then writes a control word that holds a two-bit transfer-type field, an interrupt enable and a go bit. The type field chooses between two modes. In two-cycle copying, each unit is a bus read of the source address followed by a bus write of the destination address with the data just read. In single-cycle fly-by, each unit is one bus cycle at the memory address, with a device acknowledge strobe. The I/O device sources or sinks the data itself, and the engine never holds it.

One cycle after the go bit is accepted, the engine checks the setting. An illegal type, or a fly-by memory address below the external-space boundary, ends the run with an error flag and no bus activity. Otherwise units run back to back, with no waiting on the bus. The count drops by one per unit. When it reaches zero the channel leaves busy, raises done, and pulses the interrupt when that is enabled.

Top module: `dmaChannel`

## Requirements
- R1: The type field is control word bits [1:0]: 00 is two-cycle copy, 01 is fly-by memory-to-I/O, 10 is fly-by I/O-to-memory and 11 is illegal. Bit 2 is go and bit 3 is interrupt enable. The register select is 0 for source, 1 for destination, 2 for count (low CNT_W bits) and 3 for control.
- R2: After reset the stored type is 00, and `cfgType` reports it. Busy, done, error, interrupt and all bus strobes are low, and the address and write data are zero. `cfgType` always shows the last accepted type.
- R3: In two-cycle mode each unit is one cycle with `busRd` high at the source address. The next cycle has `busWr` high at the destination address, and `busWdata` equals the `busRdata` sampled in the read cycle. `devAck` stays low in this mode.
- R4: After each unit, the memory addresses advance by UNIT_BYTES (4). In two-cycle mode both addresses advance. In fly-by mode only the destination advances, and a later run continues from the advanced values.
- R5: In fly-by mode each unit is one cycle with `devAck` high and `busAddr` equal to the destination register. Type 01 raises `busRd` and type 10 raises `busWr`, and `busWdata` stays zero.
- R6: If the type is 11 at the check cycle, no bus cycle occurs. The error flag rises and busy drops one cycle after the check.
- R7: If a fly-by type is set while the destination is below EXT_BASE, the run ends with an error and no bus activity, as in R6.
- R8: After the programmed count of units, busy drops and done rises in the cycle that follows the last unit. A count of zero gives done directly after the check cycle, with no bus activity.
- R9: When interrupt enable is set, `irq` is high for exactly the one cycle in which done rises. When it is clear, `irq` stays low.
- R10: While busy, writes to every register are ignored. This includes a control write with go set that lands in the last unit's cycle.
- R11: A control write with go set, accepted while idle, makes busy rise in the next cycle (the check cycle) and clears done and error in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select (0 source, 1 destination, 2 count, 3 control) |
| cfgWdata | input | DATA_W | Register write data |
| cfgType | output | 2 | Stored transfer type |
| busAddr | output | ADDR_W | Bus address, zero when no strobe |
| busRd | output | 1 | Bus read strobe |
| busWr | output | 1 | Bus write strobe |
| busWdata | output | DATA_W | Write data in two-cycle write beats, else zero |
| busRdata | input | DATA_W | Read data, sampled at the end of a read beat |
| devAck | output | 1 | Device acknowledge for fly-by cycles |
| busy | output | 1 | Channel active |
| done | output | 1 | Sticky completion flag, cleared on the next start |
| err | output | 1 | Sticky illegal-setting flag, cleared on the next start |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Two functions can fall in the same cycle: the step of the final unit and a register write that arrives while the channel is still busy. That write even includes a fresh go bit. The bench provokes this by pacing a burst of writes so that the last one is sampled on the edge where the final write beat ends. The cycle-by-cycle reference model must then show the channel going idle with done set, and no new check cycle. A later run must show that the addresses and count carry on from the values the engine stepped to, not from the written ones. A second overlap is done and the interrupt rising on one edge; it is judged by comparing both against the model on every cycle.

// File: rtl/dmaPkg.sv
package dmaPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD,
    ST_WR,
    ST_FLY
  } dmaState_e;

  typedef enum logic [1:0] {
    XT_TWO  = 2'b00,
    XT_M2IO = 2'b01,
    XT_IO2M = 2'b10,
    XT_BAD  = 2'b11
  } xferType_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int GO_BIT  = 2;
  localparam int IRQ_BIT = 3;

  typedef struct packed {
    logic putSrc;
    logic putDst;
    logic putData;
    logic latchData;
    logic stepUnit;
    logic stepSrc;
  } dmaStrobe_t;

endpackage

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int UNIT_BYTES = 4,
  parameter logic [ADDR_W-1:0] EXT_BASE = 'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              busyIn,
  input  dmaStrobe_t        strb,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [1:0]        typeVal,
  output logic              irqEnVal,
  output logic              cntZero,
  output logic              cntOne,
  output logic              dstInternal
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(UNIT_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] srcReg;
  logic [ADDR_W-1:0] dstReg;
  logic [CNT_W-1:0]  cntReg;
  logic [DATA_W-1:0] dataReg;
  logic [1:0]        typeReg;
  logic              irqEnReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= '0;
      dstReg   <= '0;
      cntReg   <= '0;
      dataReg  <= '0;
      typeReg  <= XT_TWO;
      irqEnReg <= 1'b0;
    end else begin
      if (cfgWe && !busyIn) begin
        case (cfgSel)
          SEL_SRC:  srcReg <= cfgWdata[ADDR_W-1:0];
          SEL_DST:  dstReg <= cfgWdata[ADDR_W-1:0];
          SEL_CNT:  cntReg <= cfgWdata[CNT_W-1:0];
          default: begin
            typeReg  <= cfgWdata[1:0];
            irqEnReg <= cfgWdata[IRQ_BIT];
          end
        endcase
      end
      if (strb.latchData) dataReg <= busRdata;
      if (strb.stepUnit) begin
        dstReg <= dstReg + STEP;
        cntReg <= cntReg - CNT_ONE;
      end
      if (strb.stepSrc) srcReg <= srcReg + STEP;
    end
  end

  always_comb begin
    busAddr = '0;
    if (strb.putSrc) busAddr = srcReg;
    else if (strb.putDst) busAddr = dstReg;
  end

  assign busWdata    = strb.putData ? dataReg : '0;
  assign typeVal     = typeReg;
  assign irqEnVal    = irqEnReg;
  assign cntZero     = (cntReg == '0);
  assign cntOne      = (cntReg == CNT_ONE);
  assign dstInternal = (dstReg < EXT_BASE);

  // R4: each unit step moves the memory address by one unit
  a_r4_dst_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepUnit |=> (dstReg == $past(dstReg) + STEP));

  // R10: with no unit step, a busy channel keeps its registers
  a_r10_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !strb.stepUnit) |=> ($stable(srcReg) && $stable(dstReg) && $stable(cntReg) && $stable(typeReg)));

endmodule

// File: rtl/dmaControl.sv
module dmaControl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic       goBit,
  input  logic [1:0] typeVal,
  input  logic       irqEnVal,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       dstInternal,
  output dmaStrobe_t strb,
  output logic       busRd,
  output logic       busWr,
  output logic       devAck,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       irq
);

  dmaState_e state;
  logic startReq;
  logic badSetting;
  logic isFly;

  assign startReq   = cfgWe && (cfgSel == SEL_CTRL) && goBit && (state == ST_IDLE);
  assign isFly      = (typeVal == XT_M2IO) || (typeVal == XT_IO2M);
  assign badSetting = (typeVal == XT_BAD) || (isFly && dstInternal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state <= ST_CHK;
            done  <= 1'b0;
            err   <= 1'b0;
          end
        end
        ST_CHK: begin
          if (badSetting) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (cntZero) begin
            done  <= 1'b1;
            irq   <= irqEnVal;
            state <= ST_IDLE;
          end else begin
            state <= isFly ? ST_FLY : ST_RD;
          end
        end
        ST_RD: state <= ST_WR;
        ST_WR, ST_FLY: begin
          if (cntOne) begin
            done  <= 1'b1;
            irq   <= irqEnVal;
            state <= ST_IDLE;
          end else begin
            state <= (state == ST_WR) ? ST_RD : ST_FLY;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.putSrc    = (state == ST_RD);
    strb.latchData = (state == ST_RD);
    strb.putDst    = (state == ST_WR) || (state == ST_FLY);
    strb.putData   = (state == ST_WR);
    strb.stepUnit  = (state == ST_WR) || (state == ST_FLY);
    strb.stepSrc   = (state == ST_WR);
  end

  assign busRd  = (state == ST_RD) || ((state == ST_FLY) && (typeVal == XT_M2IO));
  assign busWr  = (state == ST_WR) || ((state == ST_FLY) && (typeVal == XT_IO2M));
  assign devAck = (state == ST_FLY);
  assign busy   = (state != ST_IDLE);

  // R8: completion is only flagged on an idle channel
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: the interrupt comes only with completion
  a_r9_irq_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done);

  // R6: an error leaves the bus quiet
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !(busRd || busWr || devAck));

  // R5: a fly-by cycle carries exactly one direction strobe
  a_r5_ack_one: assert property (@(posedge clk) disable iff (!rstN)
    devAck |-> (busRd != busWr));

  // R3: a copy read beat is always followed by its write beat
  a_r3_rd_then_wr: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !devAck) |=> (busWr && !devAck));

endmodule

// File: rtl/dmaChannel.sv
module dmaChannel
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int UNIT_BYTES = 4,
  parameter logic [ADDR_W-1:0] EXT_BASE = 'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [1:0]        cfgType,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              devAck,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              irq
);

  dmaStrobe_t strb;
  logic [1:0] typeVal;
  logic irqEnVal;
  logic cntZero;
  logic cntOne;
  logic dstInternal;

  dmaDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .UNIT_BYTES(UNIT_BYTES), .EXT_BASE(EXT_BASE)
  ) uData (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .busyIn(busy), .strb(strb), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .typeVal(typeVal), .irqEnVal(irqEnVal),
    .cntZero(cntZero), .cntOne(cntOne), .dstInternal(dstInternal)
  );

  dmaControl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .goBit(cfgWdata[GO_BIT]), .typeVal(typeVal), .irqEnVal(irqEnVal),
    .cntZero(cntZero), .cntOne(cntOne), .dstInternal(dstInternal),
    .strb(strb), .busRd(busRd), .busWr(busWr), .devAck(devAck),
    .busy(busy), .done(done), .err(err), .irq(irq)
  );

  assign cfgType = typeVal;

endmodule

// File: tb/dmaChannel_test.sv
module dmaChannel_test;

  localparam logic [31:0] EXT = 32'h0010_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = 2'd0;
  logic [31:0] cfgWdata = '0;
  logic [1:0] cfgType;
  logic [31:0] busAddr;
  logic busRd, busWr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic devAck, busy, done, err, irq;

  always #10 clk = ~clk;

  function automatic logic [31:0] memOf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign busRdata = memOf(busAddr);

  dmaChannel uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgType(cfgType), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .devAck(devAck), .busy(busy),
    .done(done), .err(err), .irq(irq)
  );

  typedef struct {
    logic [31:0] addr;
    logic rd, wr, ack, bsy, dn, er, iq;
    logic [31:0] wdata;
    string tag;
  } rec_t;

  rec_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic lastBusy = 0, lastDone = 0, lastErr = 0;
  logic [31:0] mSrc = 0, mDst = 0;
  int mCnt = 0;
  logic [1:0] mType = 0;
  logic mIrq = 0;

  function automatic rec_t blank(input string t);
    rec_t r;
    r.addr = 0; r.rd = 0; r.wr = 0; r.ack = 0; r.bsy = 0;
    r.dn = 0; r.er = 0; r.iq = 0; r.wdata = 0; r.tag = t;
    return r;
  endfunction

  always @(negedge clk) begin
    if (rstN && !finished) begin
      rec_t e;
      if (expQ.size() > 0) e = expQ.pop_front();
      else begin
        e = blank("R2");
        e.dn = lastDone; e.er = lastErr;
      end
      lastBusy = e.bsy; lastDone = e.dn; lastErr = e.er;
      total++;
      if (busAddr !== e.addr || busRd !== e.rd || busWr !== e.wr || devAck !== e.ack ||
          busWdata !== e.wdata || busy !== e.bsy || done !== e.dn || err !== e.er ||
          irq !== e.iq || cfgType !== mType) begin
        bad++;
        $display("FAIL %s t=%0t act addr=%h rd=%b wr=%b ack=%b wd=%h busy=%b done=%b err=%b irq=%b type=%0d exp addr=%h rd=%b wr=%b ack=%b wd=%h busy=%b done=%b err=%b irq=%b type=%0d",
          e.tag, $time, busAddr, busRd, busWr, devAck, busWdata, busy, done, err, irq, cfgType,
          e.addr, e.rd, e.wr, e.ack, e.wdata, e.bsy, e.dn, e.er, e.iq, mType);
      end
    end
  end

  task automatic buildRun();
    rec_t r;
    bit flyMode;
    r = blank("R11"); r.bsy = 1; expQ.push_back(r);
    flyMode = (mType == 2'd1) || (mType == 2'd2);
    if (mType == 2'd3) begin
      r = blank("R6"); r.er = 1; expQ.push_back(r);
    end else if (flyMode && mDst < EXT) begin
      r = blank("R7"); r.er = 1; expQ.push_back(r);
    end else if (mCnt == 0) begin
      r = blank("R8"); r.dn = 1; r.iq = mIrq; expQ.push_back(r);
    end else begin
      for (int i = 0; i < mCnt; i++) begin
        if (!flyMode) begin
          r = blank("R3"); r.bsy = 1; r.rd = 1; r.addr = mSrc; expQ.push_back(r);
          r = blank("R4"); r.bsy = 1; r.wr = 1; r.addr = mDst; r.wdata = memOf(mSrc);
          expQ.push_back(r);
          mSrc += 4;
        end else begin
          r = blank("R5"); r.bsy = 1; r.ack = 1; r.addr = mDst;
          r.rd = (mType == 2'd1); r.wr = (mType == 2'd2); expQ.push_back(r);
        end
        mDst += 4;
      end
      mCnt = 0;
      r = blank("R9"); r.dn = 1; r.iq = mIrq; expQ.push_back(r);
    end
  endtask

  task automatic wrCfg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk); #1;
    cfgWe = 1; cfgSel = sel; cfgWdata = data;
    if (!lastBusy) begin
      case (sel)
        2'd0: mSrc = data;
        2'd1: mDst = data;
        2'd2: mCnt = int'(data[15:0]);
        default: begin
          mType = data[1:0]; mIrq = data[3];
          if (data[2]) buildRun();
        end
      endcase
    end
    @(negedge clk); #1;
    cfgWe = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (expQ.size() != 0 || lastBusy);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] t, input bit go, input bit ie);
    return {28'd0, ie, go, t};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1;
    repeat (3) @(negedge clk);

    // R1 R3 R4 R9: two-cycle copy, three units, interrupt on
    wrCfg(0, 32'h0000_0100); wrCfg(1, 32'h0000_0200); wrCfg(2, 3);
    wrCfg(3, ctl(2'd0, 1, 1));
    waitIdle();

    // R5: fly-by memory-to-I/O, interrupt off
    wrCfg(1, EXT + 32'h40); wrCfg(2, 2); wrCfg(3, ctl(2'd1, 1, 0));
    waitIdle();

    // R5 R4: fly-by I/O-to-memory continues from advanced destination
    wrCfg(2, 3); wrCfg(3, ctl(2'd2, 1, 1));
    waitIdle();

    // R6: illegal type
    wrCfg(2, 2); wrCfg(3, ctl(2'd3, 1, 1));
    waitIdle();

    // R7: fly-by with internal memory address
    wrCfg(1, 32'h0000_0080); wrCfg(2, 2); wrCfg(3, ctl(2'd1, 1, 1));
    waitIdle();

    // R8: zero count
    wrCfg(2, 0); wrCfg(3, ctl(2'd0, 1, 1));
    waitIdle();

    // R10: writes while busy, last one on the final write beat
    wrCfg(0, 32'h0000_1000); wrCfg(1, 32'h0000_2000); wrCfg(2, 3);
    wrCfg(3, ctl(2'd0, 1, 0));
    @(negedge clk);
    wrCfg(0, 32'h0000_5550);
    wrCfg(2, 7);
    wrCfg(3, ctl(2'd2, 1, 1));
    waitIdle();

    // R4 R10: next run continues from the stepped addresses
    wrCfg(2, 2); wrCfg(3, ctl(2'd0, 1, 1));
    waitIdle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog R8 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule